// File: doc/BRIEF.md
# Instrumentation Trace Event Merger

This block collects trace events from three producers and hands them out one at a time on a single valid/ready packet stream. Software creates events by writing words into any of 32 stimulus ports on a small register bus. A data-watch unit offers hardware events through a valid/ready input. An internal timestamp counter offers a timestamp packet after other traffic has gone out, so a downstream trace formatter can tell how much time passed between events.

Each stimulus port has a one-word buffer. A software write lands there only if the port is enabled, the port is not locked against unprivileged access, and the buffer is empty. A fixed arbiter fills a single output register. Software buffers always beat the hardware input, and the hardware input always beats a pending timestamp. A global trace-enable input stops the whole block: it takes no writes and starts no new packets. Build parameters can remove stimulus ports or control registers, and a removed register reads as zero.

Top module: `trace_event_mux`

## Requirements
- R1: After reset, pkt_valid is 0, the enable register (0xE00) and the lock register (0xE40) read 0, and each stimulus port (byte offset 4*n, n = 0..31) reads 1 in bit 0.
- R2: A write to stimulus port n while enable bit n is set produces one packet with pkt_src = 2'b01, pkt_port = n and pkt_data = the written word.
- R3: A write to stimulus port n while enable bit n is clear is dropped and produces no packet.
- R4: Bit g of the lock register covers ports 8g to 8g+7. While that bit is set, writes to those ports with bus_priv = 0 are dropped, and writes with bus_priv = 1 are accepted.
- R5: Reading a stimulus port returns 1 in bit 0 when its one-word buffer is empty and 0 when it is full. A write to a full port is dropped and leaves the buffered word unchanged.
- R6: When several sources are ready, software buffers go out first, lowest port number first, then the hardware input, then a pending timestamp.
- R7: A hardware event is taken when hw_valid and hw_ready are both 1 at a clock edge. It becomes a packet with pkt_src = 2'b10, pkt_port = hw_port and pkt_data = hw_data.
- R8: A timestamp packet (pkt_src = 2'b11, pkt_port = 0, pkt_data = counter value) is queued only after a software or hardware packet has been sent. One timestamp covers a whole run of such packets, and the counter is cleared when the timestamp is loaded.
- R9: The counter is TS_W bits wide (21 by default). It advances on each clock when ts_sel = 0 and on each ts_tick pulse when ts_sel = 1. At its maximum it saturates instead of wrapping.
- R10: While trace_on is 0, no register write is accepted, no hw_ready is given, no new packet starts and the counter holds.
- R11: While pkt_valid = 1 and pkt_ready = 0, pkt_valid stays 1 and the packet fields stay unchanged.
- R12: A stimulus port or control register that the build parameters mark as absent reads as zero. A write to an absent stimulus port produces no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| trace_on | input | 1 | Global trace enable |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_priv | input | 1 | Write comes from privileged code |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| hw_valid | input | 1 | Hardware event offered |
| hw_port | input | 5 | Hardware event identifier |
| hw_data | input | 32 | Hardware event payload |
| hw_ready | output | 1 | Hardware event taken this cycle |
| ts_sel | input | 1 | Counter source: 0 core clock, 1 ts_tick |
| ts_tick | input | 1 | Increment pulse at the trace bit rate |
| pkt_valid | output | 1 | Output packet valid |
| pkt_ready | input | 1 | Output packet accepted |
| pkt_src | output | 2 | Source tag |
| pkt_port | output | 5 | Port or event number |
| pkt_data | output | 32 | Payload |

## Verification
The bench fills two software buffers and holds the hardware input while the output is stalled. When the output is released, it expects the lower port first, then the higher one, then the hardware event, then one timestamp. A design that orders by arrival or lets hardware jump ahead would show a different order. It writes a port whose buffer is already full, checks that the status bit reads busy, and expects only two packets. An overwriting buffer would send the third word instead of the second. Timestamp values are pinned by counting ticks, including ticks given while tracing is off, and by running the free clock mode long enough to reach the top of a narrowed counter. A wrapping counter or one that counts while disabled would give a different payload.

// File: rtl/evtr_pkg.sv
package evtr_pkg;
  localparam int PORT_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SW   = 2'b01,
    SRC_HW   = 2'b10,
    SRC_TS   = 2'b11
  } src_e;

  typedef struct packed {
    src_e              src;
    logic [PORT_W-1:0] port;
    logic [DATA_W-1:0] data;
  } pkt_t;

  // lock group that covers a stimulus port
  function automatic int unsigned grp_of(int unsigned port);
    return port / 8;
  endfunction

  // next counter value: clear wins, then a saturating step
  function automatic logic [31:0] ts_step(logic [31:0] cnt, logic [31:0] maxv,
                                          logic adv, logic clr);
    if (clr) return 32'd0;
    if (adv && cnt != maxv) return cnt + 32'd1;
    return cnt;
  endfunction
endpackage

// File: rtl/evtr_regs.sv
module evtr_regs import evtr_pkg::*; #(
  parameter int                 N_PORTS = 32,
  parameter logic [N_PORTS-1:0] PRESENT = '1,
  parameter bit                 HAS_TER = 1'b1,
  parameter bit                 HAS_TPR = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             trace_on,
  input  logic                             bus_rd,
  input  logic                             bus_wr,
  input  logic                             bus_priv,
  input  logic [11:0]                      bus_addr,
  input  logic [31:0]                      bus_wdata,
  input  logic [N_PORTS-1:0]               pop,
  output logic [31:0]                      bus_rdata,
  output logic [N_PORTS-1:0]               full,
  output logic [N_PORTS-1:0][DATA_W-1:0]   buf_data
);
  localparam int         N_GRP    = (N_PORTS + 7) / 8;
  localparam logic [11:0] ENA_ADDR = 12'hE00;
  localparam logic [11:0] LCK_ADDR = 12'hE40;

  logic [N_PORTS-1:0] ena_q;
  logic [N_GRP-1:0]   lck_q;
  logic [N_PORTS-1:0] sel, locked, stim_acc;
  logic               stim_hit, wr_en, ena_wr, lck_wr;

  assign wr_en    = bus_wr && trace_on;
  assign stim_hit = (bus_addr[11:7] == 5'd0) && (bus_addr[1:0] == 2'b00);
  assign ena_wr   = wr_en && HAS_TER && (bus_addr == ENA_ADDR);
  assign lck_wr   = wr_en && HAS_TPR && (bus_addr == LCK_ADDR);

  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      sel[i]    = stim_hit && (bus_addr[6:2] == 5'(i));
      locked[i] = lck_q[grp_of(i)] && !bus_priv;
    end
  end

  // a write lands only in an empty, present, enabled, unlocked buffer
  assign stim_acc = {N_PORTS{wr_en}} & sel & PRESENT & ena_q & ~locked & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      lck_q <= '0;
      full  <= '0;
    end else begin
      if (ena_wr) ena_q <= bus_wdata[N_PORTS-1:0];
      if (lck_wr) lck_q <= bus_wdata[N_GRP-1:0];
      full <= (full & ~pop) | stim_acc;
    end
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           buf_data[g] <= '0;
      else if (stim_acc[g]) buf_data[g] <= bus_wdata;
    end

    // R5
    held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full[g] && !pop[g]) |=> (full[g] && $stable(buf_data[g])));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (|(sel & PRESENT)) bus_rdata[0] = ~|(sel & PRESENT & full);
      if (HAS_TER && bus_addr == ENA_ADDR) bus_rdata[N_PORTS-1:0] = ena_q;
      if (HAS_TPR && bus_addr == LCK_ADDR) bus_rdata[N_GRP-1:0] = lck_q;
    end
  end

  // R10
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_on |=> ($stable(ena_q) && $stable(lck_q) && ((full & ~$past(full)) == '0)));
endmodule

// File: rtl/evtr_tstamp.sv
module evtr_tstamp import evtr_pkg::*; #(
  parameter int TS_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trace_on,
  input  logic            ts_sel,
  input  logic            ts_tick,
  input  logic            clr,
  output logic [TS_W-1:0] cnt
);
  localparam logic [TS_W-1:0] TS_MAX   = '1;
  localparam logic [31:0]     TS_MAX32 = 32'(TS_MAX);

  logic adv;
  assign adv = trace_on && (ts_sel ? ts_tick : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= TS_W'(ts_step(32'(cnt), TS_MAX32, adv, clr));
  end

  // R9
  ts_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TS_MAX && !clr) |=> (cnt == TS_MAX));

  // R10
  ts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_on && !clr) |=> $stable(cnt));

  // R8
  ts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/evtr_arb.sv
module evtr_arb import evtr_pkg::*; #(
  parameter int N_PORTS = 32,
  parameter int TS_W    = 21
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           trace_on,
  input  logic [N_PORTS-1:0]             full,
  input  logic [N_PORTS-1:0][DATA_W-1:0] buf_data,
  input  logic                           hw_valid,
  input  logic [PORT_W-1:0]              hw_port,
  input  logic [DATA_W-1:0]              hw_data,
  output logic                           hw_ready,
  input  logic [TS_W-1:0]                ts_cnt,
  output logic                           ts_clr,
  output logic [N_PORTS-1:0]             pop,
  input  logic                           pkt_ready,
  output logic                           pkt_valid,
  output pkt_t                           pkt
);
  logic              out_free, take, sw_any, load, ts_pend, sent_evt;
  logic [PORT_W-1:0] sw_idx;
  src_e              pick;
  pkt_t              nxt;

  assign out_free = !pkt_valid || pkt_ready;
  assign take     = trace_on && out_free;
  assign sw_any   = |full;

  // lowest full port wins among software buffers
  always_comb begin
    logic found;
    found  = 1'b0;
    sw_idx = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (full[i] && !found) begin
        sw_idx = PORT_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    if (sw_any)        pick = SRC_SW;
    else if (hw_valid) pick = SRC_HW;
    else if (ts_pend)  pick = SRC_TS;
    else               pick = SRC_NONE;
  end

  always_comb begin
    nxt.src  = pick;
    nxt.port = '0;
    nxt.data = '0;
    case (pick)
      SRC_SW: begin nxt.port = sw_idx;  nxt.data = buf_data[sw_idx]; end
      SRC_HW: begin nxt.port = hw_port; nxt.data = hw_data;          end
      SRC_TS: nxt.data = DATA_W'(ts_cnt);
      default: ;
    endcase
  end

  assign load     = take && (pick != SRC_NONE);
  assign hw_ready = take && !sw_any;
  assign ts_clr   = load && (pick == SRC_TS);
  assign pop      = (load && pick == SRC_SW) ?
                    ({{(N_PORTS-1){1'b0}}, 1'b1} << sw_idx) : '0;
  assign sent_evt = pkt_valid && pkt_ready && (pkt.src != SRC_TS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid <= 1'b0;
      pkt       <= '0;
      ts_pend   <= 1'b0;
    end else begin
      if (load) begin
        pkt_valid <= 1'b1;
        pkt       <= nxt;
      end else if (pkt_ready) begin
        pkt_valid <= 1'b0;
      end
      ts_pend <= ts_clr ? 1'b0 : (ts_pend | sent_evt);
    end
  end

  // R11
  hold_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt)));

  // R6
  hw_after_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hw_ready) |-> (full == '0));

  // R10
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_on |=> !$rose(pkt_valid));

  // R5
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop));
endmodule

// File: rtl/trace_event_mux.sv
module trace_event_mux import evtr_pkg::*; #(
  parameter int          N_PORTS      = 32,
  parameter int          TS_W         = 21,
  parameter logic [31:0] STIM_PRESENT = 32'hFFFF_FFFF,
  parameter bit          HAS_TER      = 1'b1,
  parameter bit          HAS_TPR      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trace_on,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_priv,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        hw_valid,
  input  logic [4:0]  hw_port,
  input  logic [31:0] hw_data,
  output logic        hw_ready,
  input  logic        ts_sel,
  input  logic        ts_tick,
  output logic        pkt_valid,
  input  logic        pkt_ready,
  output logic [1:0]  pkt_src,
  output logic [4:0]  pkt_port,
  output logic [31:0] pkt_data
);
  logic [N_PORTS-1:0]             full, pop;
  logic [N_PORTS-1:0][DATA_W-1:0] buf_data;
  logic [TS_W-1:0]                ts_cnt;
  logic                           ts_clr;
  pkt_t                           pkt;

  evtr_regs #(
    .N_PORTS(N_PORTS), .PRESENT(STIM_PRESENT[N_PORTS-1:0]),
    .HAS_TER(HAS_TER), .HAS_TPR(HAS_TPR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .trace_on(trace_on), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_priv(bus_priv), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pop(pop), .bus_rdata(bus_rdata),
    .full(full), .buf_data(buf_data)
  );

  evtr_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .trace_on(trace_on), .ts_sel(ts_sel),
    .ts_tick(ts_tick), .clr(ts_clr), .cnt(ts_cnt)
  );

  evtr_arb #(.N_PORTS(N_PORTS), .TS_W(TS_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .trace_on(trace_on), .full(full),
    .buf_data(buf_data), .hw_valid(hw_valid), .hw_port(hw_port),
    .hw_data(hw_data), .hw_ready(hw_ready), .ts_cnt(ts_cnt),
    .ts_clr(ts_clr), .pop(pop), .pkt_ready(pkt_ready),
    .pkt_valid(pkt_valid), .pkt(pkt)
  );

  assign pkt_src  = pkt.src;
  assign pkt_port = pkt.port;
  assign pkt_data = pkt.data;
endmodule

// File: tb/sim_trace_event_mux.sv
module sim_trace_event_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_on = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        hw_valid = 1'b0, hw_ready;
  logic [4:0]  hw_port = '0;
  logic [31:0] hw_data = '0;
  logic        ts_sel = 1'b1, ts_tick = 1'b0;
  logic        pkt_valid, pkt_ready = 1'b1;
  logic [1:0]  pkt_src;
  logic [4:0]  pkt_port;
  logic [31:0] pkt_data;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [38:0] exp_q[$];
  string       req_q[$];

  localparam logic [11:0] A_ENA = 12'hE00, A_LCK = 12'hE40;

  always #2 clk = ~clk;

  trace_event_mux #(.TS_W(6), .STIM_PRESENT(32'h7FFF_FFFF)) u0 (
    .clk(clk), .rst_n(rst_n), .trace_on(trace_on), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_priv(bus_priv), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_valid(hw_valid),
    .hw_port(hw_port), .hw_data(hw_data), .hw_ready(hw_ready),
    .ts_sel(ts_sel), .ts_tick(ts_tick), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_src(pkt_src), .pkt_port(pkt_port),
    .pkt_data(pkt_data)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_pkt(logic [1:0] src, logic [4:0] port, logic [31:0] data, string req);
    exp_q.push_back({src, port, data});
    req_q.push_back(req);
  endtask

  // scoreboard monitor: every handshake must match the queue head
  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected packet", {pkt_src, pkt_port, pkt_data}, 64'd0);
      end else begin
        logic [38:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({pkt_src, pkt_port, pkt_data} == e, r, {pkt_src, pkt_port, pkt_data}, e);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic priv);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = priv;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_priv = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic hw_send(logic [4:0] p, logic [31:0] d);
    @(posedge clk); #1;
    hw_valid = 1'b1; hw_port = p; hw_data = d;
    forever begin
      @(negedge clk);
      if (hw_ready) break;
    end
    @(posedge clk); #1;
    hw_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1 ts_tick = 1'b1;
    @(posedge clk); #1 ts_tick = 1'b0;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (12) @(posedge clk);
    chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    exp_q.delete(); req_q.delete();
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    report();
  end

  initial begin
    logic [31:0] v, s0, s1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 valid", 64'(pkt_valid), 64'd0);
    rd(A_ENA, v); chk(v == 32'd0, "R1 enable reg", 64'(v), 64'd0);
    rd(A_LCK, v); chk(v == 32'd0, "R1 lock reg", 64'(v), 64'd0);
    rd(12'h000, v); chk(v == 32'd1, "R1 port0 status", 64'(v), 64'd1);
    #1 trace_on = 1'b1;

    // R3 with the enable register still zero every write is dropped
    wr(12'h008, 32'h1111_0002, 1'b1);
    drain("R3 dropped while enables clear");

    // R2 basic software packet, each followed by one timestamp (R8)
    wr(A_ENA, 32'hFFFF_FFFE, 1'b1);
    expect_pkt(2'b01, 5'd3, 32'hA5A5_0003, "R2 port3 packet");
    expect_pkt(2'b11, 5'd0, 32'd0, "R8 timestamp after port3");
    wr(12'h00C, 32'hA5A5_0003, 1'b0);
    drain("R2 drain");

    // R3 port 0 disabled
    wr(12'h000, 32'hDEAD_0000, 1'b0);
    drain("R3 disabled port0");
    wr(A_ENA, 32'hFFFF_FFFF, 1'b1);

    // R4 lock group 1 covers ports 8..15
    wr(A_LCK, 32'h0000_0002, 1'b1);
    rd(A_LCK, v); chk(v == 32'd2, "R4 lock readback", 64'(v), 64'd2);
    wr(12'h024, 32'hBAD0_0009, 1'b0);
    drain("R4 unprivileged write dropped");
    expect_pkt(2'b01, 5'd9, 32'h600D_0009, "R4 privileged write");
    expect_pkt(2'b11, 5'd0, 32'd0, "R8 timestamp after port9");
    wr(12'h024, 32'h600D_0009, 1'b1);
    drain("R4 drain");
    expect_pkt(2'b01, 5'd2, 32'h0000_2222, "R4 other group unaffected");
    expect_pkt(2'b11, 5'd0, 32'd0, "R8 timestamp after port2");
    wr(12'h008, 32'h0000_2222, 1'b0);
    drain("R4 drain 2");
    wr(A_LCK, 32'h0, 1'b1);

    // R12 port 31 built as absent
    rd(12'h07C, v); chk(v == 32'd0, "R12 absent port reads zero", 64'(v), 64'd0);
    wr(12'h07C, 32'h3131_3131, 1'b1);
    drain("R12 absent port write dropped");

    // R5 full buffer: status and drop
    #1 pkt_ready = 1'b0;
    wr(12'h00C, 32'h0000_000A, 1'b0);
    wr(12'h00C, 32'h0000_000B, 1'b0);
    rd(12'h00C, v); chk(v == 32'd0, "R5 full status", 64'(v), 64'd0);
    wr(12'h00C, 32'h0000_000C, 1'b0);
    expect_pkt(2'b01, 5'd3, 32'h0000_000A, "R5 first word");
    expect_pkt(2'b01, 5'd3, 32'h0000_000B, "R5 buffered word kept");
    expect_pkt(2'b11, 5'd0, 32'd0, "R8 one timestamp per run");
    @(posedge clk); #1 pkt_ready = 1'b1;
    drain("R5 drain");
    rd(12'h00C, v); chk(v == 32'd1, "R5 empty status", 64'(v), 64'd1);

    // R6 priority: software lowest first, then hardware, then timestamp
    #1 pkt_ready = 1'b0;
    wr(12'h01C, 32'h7777_0007, 1'b0);
    wr(12'h018, 32'h6666_0006, 1'b0);
    wr(12'h010, 32'h4444_0004, 1'b0);
    @(negedge clk); s0 = pkt_data;
    chk(pkt_valid == 1'b1, "R11 valid held", 64'(pkt_valid), 64'd1);
    expect_pkt(2'b01, 5'd7, 32'h7777_0007, "R6 first loaded");
    expect_pkt(2'b01, 5'd4, 32'h4444_0004, "R6 lowest port next");
    expect_pkt(2'b01, 5'd6, 32'h6666_0006, "R6 higher port");
    expect_pkt(2'b10, 5'd9, 32'h4848_0009, "R7 hardware after software");
    expect_pkt(2'b11, 5'd0, 32'd0, "R6 timestamp last");
    fork
      hw_send(5'd9, 32'h4848_0009);
      begin
        repeat (4) @(negedge clk);
        chk(hw_ready == 1'b0, "R7 no hw_ready while stalled", 64'(hw_ready), 64'd0);
        s1 = pkt_data;
        chk(s1 == s0, "R11 data stable", 64'(s1), 64'(s0));
        @(posedge clk); #1 pkt_ready = 1'b1;
      end
    join
    drain("R6 drain");

    // R7 hardware alone
    expect_pkt(2'b10, 5'd17, 32'hC0DE_0011, "R7 hardware packet");
    expect_pkt(2'b11, 5'd0, 32'd0, "R8 timestamp after hardware");
    hw_send(5'd17, 32'hC0DE_0011);
    drain("R7 drain");

    // R10 global enable off
    @(posedge clk); #1 trace_on = 1'b0;
    wr(A_ENA, 32'h0, 1'b1);
    rd(A_ENA, v); chk(v == 32'hFFFF_FFFF, "R10 enable reg not written", 64'(v), 64'hFFFF_FFFF);
    wr(12'h004, 32'h0FF0_0001, 1'b1);
    @(posedge clk); #1 hw_valid = 1'b1; hw_port = 5'd1; hw_data = 32'h1;
    @(negedge clk);
    chk(hw_ready == 1'b0, "R10 no hw_ready", 64'(hw_ready), 64'd0);
    @(posedge clk); #1 hw_valid = 1'b0;
    // R10 ticks while off do not count
    tick(); tick(); tick();
    @(posedge clk); #1 trace_on = 1'b1;
    drain("R10 nothing sent");
    rd(12'h004, v); chk(v == 32'd1, "R10 port1 buffer stayed empty", 64'(v), 64'd1);

    // R9 tick mode: five pulses
    tick(); tick(); tick(); tick(); tick();
    expect_pkt(2'b01, 5'd0, 32'h0000_D00D, "R9 carrier packet");
    expect_pkt(2'b11, 5'd0, 32'd5, "R9 tick count");
    wr(12'h000, 32'h0000_D00D, 1'b0);
    drain("R9 tick drain");

    // R9 core clock mode saturates at 2^6-1 on this build
    @(posedge clk); #1 ts_sel = 1'b0;
    repeat (100) @(posedge clk);
    expect_pkt(2'b01, 5'd1, 32'h0000_5A7E, "R9 carrier packet 2");
    expect_pkt(2'b11, 5'd0, 32'd63, "R9 saturated count");
    wr(12'h004, 32'h0000_5A7E, 1'b0);
    drain("R9 saturation drain");

    report();
  end
endmodule